// File: doc/BRIEF.md
# Multiplexed Boot ROM Access Bridge

This block lets a host register port read and write single bytes of an external 8-bit boot ROM, or of an external register, over a narrow pin budget. It uses eight shared address/data lines and two auxiliary lines. Each access goes out as three back-to-back bus phases. First come two address phases, which external latches capture. Then comes one data phase, in which the byte moves.

The first address phase carries the low address bits together with the active-low read and write controls. The second address phase carries the middle address byte. When the large (256 KB) configuration is enabled, one auxiliary line carries the top two address bits serially, one bit per address phase. The other auxiliary line strobes the external latches. In the data phase both auxiliary lines show the two lowest address bits.

Every phase lasts a programmable number of clocks, so slow parts can be met. A read returns its byte through a one-clock response pulse.

Top module: `romLatchBridge`

## Requirements
- R1: `reqReady` is high exactly when no access is in progress. A request is accepted on a rising edge where `reqValid` and `reqReady` are both high. A `reqValid` raised during an access starts nothing.
- R2: After acceptance, the access runs as three phases in this order: address one, address two, data. Each phase lasts `cfgCycleClks` clocks, and a value of 0 counts as 1. `romCeN` is low from the first clock after acceptance through the last data clock, and high at all other times.
- R3: In address phase one, `romBusOut[7:2]` = addr[7:2], `romBusOut[1]` = read-enable-n (0 for a read), and `romBusOut[0]` = write-enable-n (0 for a write).
- R4: In address phase two, `romBusOut[7:0]` = addr[15:8].
- R5: `romAux[0]` is addr[16] in address phase one and addr[17] in address phase two when `cfgWide` is 1. It is 0 in both address phases when `cfgWide` is 0.
- R6: `romAux[1]` is the latch strobe: 1 in address phase one and 0 in address phase two. In the data phase `romAux` = addr[1:0]. When idle, `romAux` = 0.
- R7: `romBusOe` is high in both address phases and in a write's data phase, where `romBusOut` = the write byte. It is low in a read's data phase and when idle.
- R8: A read samples `romBusIn` on the last clock of the data phase. `rspValid` is then high for exactly one clock, the first idle clock, with `rspData` holding the sampled byte. A write produces no `rspValid`.
- R9: `cfgCycleClks` and `cfgWide` are captured at acceptance. Changing them during an access does not alter that access.
- R10: During reset the bridge is idle: `reqReady` 1, `romCeN` 1, `romBusOe` 0, `rspValid` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Bridge idle, request can be taken |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Byte address |
| reqWData | input | 8 | Write byte |
| cfgWide | input | 1 | Large configuration: send addr[17:16] |
| cfgCycleClks | input | 4 | Clocks per phase (0 treated as 1) |
| rspValid | output | 1 | Read data valid pulse |
| rspData | output | 8 | Read byte |
| romCeN | output | 1 | Active-low chip enable |
| romAux | output | 2 | Auxiliary lines: [1] latch strobe / addr[1], [0] high addr / addr[0] |
| romBusOut | output | 8 | Multiplexed bus output value |
| romBusOe | output | 1 | Bus driver enable |
| romBusIn | input | 8 | Multiplexed bus input value |

## Verification
The bench builds the bridge with the default 4-bit phase counter, so the whole 0..15 setting range is reachable, including the 0-as-1 rule and the longest 15-clock phases. Vectors cover phase lengths of 1, 2, 3 and 15 clocks, reads and writes, and both address-width modes, with addresses whose top bits differ. The returned byte is presented only on the final data clock, which shows that the capture happens on that clock. The directed cases change the configuration and raise a request in mid-access.

// File: rtl/romLatchPkg.sv
package romLatchPkg;
  localparam int ADDR_W = 18;
  localparam int BUS_W  = 8;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADR1 = 2'd1,
    PH_ADR2 = 2'd2,
    PH_DATA = 2'd3
  } phase_t;

  typedef struct packed {
    logic   load;
    logic   capture;
    phase_t phase;
  } ctrlStrobes_t;
endpackage

// File: rtl/romLatchCtrl.sv
module romLatchCtrl
  import romLatchPkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [CNT_W-1:0] cfgCycleClks,
  output logic             reqReady,
  output ctrlStrobes_t     strb
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_t           state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len;
  logic [CNT_W-1:0] startLen;
  logic             accept;
  logic             lastClk;

  assign startLen = (cfgCycleClks == '0) ? ONE : cfgCycleClks;
  assign reqReady = (state == PH_IDLE);
  assign accept   = reqReady && reqValid;
  assign lastClk  = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= PH_IDLE;
      cnt   <= '0;
      len   <= ONE;
    end else begin
      case (state)
        PH_IDLE: begin
          if (accept) begin
            state <= PH_ADR1;
            len   <= startLen;
            cnt   <= startLen - ONE;
          end
        end
        default: begin
          if (lastClk) begin
            cnt <= len - ONE;
            case (state)
              PH_ADR1: state <= PH_ADR2;
              PH_ADR2: state <= PH_DATA;
              default: state <= PH_IDLE;
            endcase
          end else begin
            cnt <= cnt - ONE;
          end
        end
      endcase
    end
  end

  always_comb begin
    strb.load    = accept;
    strb.capture = (state == PH_DATA) && lastClk;
    strb.phase   = state;
  end

  // R1: an accepted request always opens address phase one
  a_r1_accept_starts: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (state == PH_ADR1));

  // R2: the phase counter never reaches the captured phase length
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state != PH_IDLE) |-> (cnt < len));

  // R2: address phase two is only entered from address phase one
  a_r2_order: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_ADR2) |-> ($past(state) == PH_ADR1 || $past(state) == PH_ADR2));

  // R2: the data phase is only entered from address phase two
  a_r2_data_order: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_DATA) |-> ($past(state) == PH_ADR2 || $past(state) == PH_DATA));
endmodule

// File: rtl/romLatchPath.sv
module romLatchPath
  import romLatchPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BUS_W-1:0]  reqWData,
  input  logic              cfgWide,
  input  logic [BUS_W-1:0]  romBusIn,
  output logic              rspValid,
  output logic [BUS_W-1:0]  rspData,
  output logic              romCeN,
  output logic [1:0]        romAux,
  output logic [BUS_W-1:0]  romBusOut,
  output logic              romBusOe
);
  logic [ADDR_W-1:0] aReg;
  logic [BUS_W-1:0]  dReg;
  logic              wrReg;
  logic              wideReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aReg     <= '0;
      dReg     <= '0;
      wrReg    <= 1'b0;
      wideReg  <= 1'b0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (strb.load) begin
        aReg    <= reqAddr;
        dReg    <= reqWData;
        wrReg   <= reqWrite;
        wideReg <= cfgWide;
      end
      rspValid <= strb.capture && !wrReg;
      if (strb.capture && !wrReg) rspData <= romBusIn;
    end
  end

  always_comb begin
    romCeN    = 1'b0;
    romAux    = 2'b00;
    romBusOut = '0;
    romBusOe  = 1'b0;
    case (strb.phase)
      PH_ADR1: begin
        romBusOut = {aReg[7:2], wrReg, !wrReg};
        romAux    = {1'b1, wideReg & aReg[16]};
        romBusOe  = 1'b1;
      end
      PH_ADR2: begin
        romBusOut = aReg[15:8];
        romAux    = {1'b0, wideReg & aReg[17]};
        romBusOe  = 1'b1;
      end
      PH_DATA: begin
        romBusOut = wrReg ? dReg : '0;
        romAux    = aReg[1:0];
        romBusOe  = wrReg;
      end
      default: romCeN = 1'b1;
    endcase
  end

  // R7: drivers released while a read's data phase is running
  a_r7_read_release: assert property (@(posedge clk) disable iff (!rstN)
    (strb.phase == PH_DATA && !wrReg) |-> !romBusOe);

  // R3: exactly one of the two control bits is asserted low in phase one
  a_r3_one_ctrl: assert property (@(posedge clk) disable iff (!rstN)
    (strb.phase == PH_ADR1) |-> ($countones(romBusOut[1:0]) == 1));

  // R8: a read response lasts a single clock
  a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R5: narrow mode keeps the high-address line low in address phases
  a_r5_narrow: assert property (@(posedge clk) disable iff (!rstN)
    (!wideReg && (strb.phase == PH_ADR1 || strb.phase == PH_ADR2)) |-> !romAux[0]);
endmodule

// File: rtl/romLatchBridge.sv
module romLatchBridge
  import romLatchPkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqWrite,
  input  logic [17:0]      reqAddr,
  input  logic [7:0]       reqWData,
  input  logic             cfgWide,
  input  logic [CNT_W-1:0] cfgCycleClks,
  output logic             rspValid,
  output logic [7:0]       rspData,
  output logic             romCeN,
  output logic [1:0]       romAux,
  output logic [7:0]       romBusOut,
  output logic             romBusOe,
  input  logic [7:0]       romBusIn
);
  ctrlStrobes_t strb;

  romLatchCtrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .cfgCycleClks (cfgCycleClks),
    .reqReady     (reqReady),
    .strb         (strb)
  );

  romLatchPath u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .reqWData  (reqWData),
    .cfgWide   (cfgWide),
    .romBusIn  (romBusIn),
    .rspValid  (rspValid),
    .rspData   (rspData),
    .romCeN    (romCeN),
    .romAux    (romAux),
    .romBusOut (romBusOut),
    .romBusOe  (romBusOe)
  );

  // R2: chip enable high means the bus is never driven
  a_r2_ce_idle: assert property (@(posedge clk) disable iff (!rstN)
    romCeN |-> !romBusOe);

  // R1: the bridge only takes requests while deselected
  a_r1_ready_deselected: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> romCeN);
endmodule

// File: tb/romLatchBridge_bench.sv
module romLatchBridge_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqReady, reqWrite, cfgWide, rspValid, romCeN, romBusOe;
  logic [17:0] reqAddr;
  logic [7:0]  reqWData, rspData, romBusOut, romBusIn;
  logic [3:0]  cfgCycleClks;
  logic [1:0]  romAux;

  int  nRun = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  romLatchBridge u_romLatchBridge (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWData(reqWData),
    .cfgWide(cfgWide), .cfgCycleClks(cfgCycleClks), .rspValid(rspValid),
    .rspData(rspData), .romCeN(romCeN), .romAux(romAux),
    .romBusOut(romBusOut), .romBusOe(romBusOe), .romBusIn(romBusIn)
  );

  // {write, addr[17:0], wdata, wide, clks, romByte}
  localparam int NV = 7;
  localparam logic [39:0] VECS [NV] = '{
    {1'b0, 18'h2A5C7, 8'h00, 1'b1, 4'd1,  8'h96},
    {1'b1, 18'h1F0E1, 8'hC3, 1'b1, 4'd2,  8'h00},
    {1'b0, 18'h3FFFE, 8'h00, 1'b0, 4'd3,  8'h5A},
    {1'b1, 18'h20102, 8'h7E, 1'b0, 4'd1,  8'h00},
    {1'b0, 18'h10004, 8'h00, 1'b1, 4'd0,  8'hE1},
    {1'b0, 18'h0ABCD, 8'h00, 1'b1, 4'd15, 8'h3C},
    {1'b1, 18'h30033, 8'hA5, 1'b1, 4'd3,  8'h00}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runAccess(input logic [39:0] v, input bit perturb);
    logic        wr;
    logic [17:0] a;
    logic [7:0]  wd, rb, expBus;
    logic        wide;
    logic [3:0]  clks;
    logic [1:0]  expAux;
    logic        expOe;
    int          n;
    {wr, a, wd, wide, clks, rb} = v;
    n = (clks == 0) ? 1 : int'(clks);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWData = wd;
    cfgWide = wide; cfgCycleClks = clks; romBusIn = ~rb;
    check(reqReady == 1'b1, "R1 ready before accept", 32'(reqReady), 1);
    @(negedge clk);
    reqValid = perturb;
    reqAddr = ~a; reqWData = ~wd; reqWrite = ~wr;
    if (perturb) begin
      cfgCycleClks = (n == 1) ? 4'd4 : 4'd1;
      cfgWide = ~wide;
    end
    for (int ph = 0; ph < 3; ph++) begin
      for (int k = 0; k < n; k++) begin
        if (ph == 2 && k == n - 1) romBusIn = rb;
        case (ph)
          0: begin expBus = {a[7:2], wr, ~wr}; expAux = {1'b1, wide & a[16]}; expOe = 1'b1; end
          1: begin expBus = a[15:8]; expAux = {1'b0, wide & a[17]}; expOe = 1'b1; end
          default: begin expBus = wd; expAux = a[1:0]; expOe = wr; end
        endcase
        check(romCeN == 1'b0 && reqReady == 1'b0, "R2/R1 busy ce/ready",
              {30'd0, romCeN, reqReady}, 0);
        check(romAux == expAux, (ph == 2) ? "R6 data aux" : "R5/R6 addr aux",
              32'(romAux), 32'(expAux));
        check(romBusOe == expOe, "R7 driver enable", 32'(romBusOe), 32'(expOe));
        if (ph == 0) check(romBusOut == expBus, "R3 first address byte", 32'(romBusOut), 32'(expBus));
        if (ph == 1) check(romBusOut == expBus, "R4 second address byte", 32'(romBusOut), 32'(expBus));
        if (ph == 2 && wr) check(romBusOut == expBus, "R7 write data", 32'(romBusOut), 32'(expBus));
        @(negedge clk);
      end
    end
    reqValid = 1'b0;
    romBusIn = ~rb;
    check(romCeN == 1'b1 && romBusOe == 1'b0 && reqReady == 1'b1, "R2 idle after data",
          {29'd0, romCeN, romBusOe, reqReady}, 32'b101);
    check(romAux == 2'b00, "R6 idle aux", 32'(romAux), 0);
    check(rspValid == !wr, "R8 response valid", 32'(rspValid), 32'(!wr));
    if (!wr) check(rspData == rb, "R8 read byte", 32'(rspData), 32'(rb));
    @(negedge clk);
    check(rspValid == 1'b0, "R8 single pulse", 32'(rspValid), 0);
    if (perturb) begin
      for (int i = 0; i < 3; i++) begin
        check(romCeN == 1'b1, "R1 busy request ignored", 32'(romCeN), 1);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqWData = '0;
    cfgWide = 1'b0; cfgCycleClks = 4'd1; romBusIn = '0;
    repeat (3) @(negedge clk);
    reqValid = 1'b1;
    @(negedge clk);
    check(reqReady && romCeN && !romBusOe && !rspValid, "R10 reset state",
          {28'd0, reqReady, romCeN, romBusOe, rspValid}, 32'b1100);
    reqValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check(romCeN == 1'b1, "R10 no access after reset", 32'(romCeN), 1);

    for (int i = 0; i < NV; i++) runAccess(VECS[i], 1'b0);

    // R9 and R1: change setup and raise a request mid-access
    runAccess({1'b0, 18'h35A69, 8'h00, 1'b0, 4'd2, 8'h81}, 1'b1);
    runAccess({1'b1, 18'h0C3F2, 8'h18, 1'b1, 4'd1, 8'h00}, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule